// File: doc/BRIEF.md
# DMA Bus Bandwidth Throttle

This block sits between the read/write sequencer of a DMA engine and the logic that raises bus requests. It limits how much bus bandwidth one executing channel can take. A 2-bit bandwidth code selects the policy. The block can leave the sequencer free, raise the channel's priority at the bus arbiter, or hold off the next access for a fixed number of cycles after each completed read/write access.

The sequencer reports every completed access with a one-cycle strobe. It flags the strobe that ends a minor loop with a last-write indication. The first two accesses of channel execution form a warm-up window. No stall is inserted during that window and priority stays low, so a channel starts quickly. A stall is also never inserted after the final write of a minor loop. Dropping channel-active clears both outputs and the warm-up count. A one-cycle channel-start pulse restarts the warm-up count.

The control is a four-state machine:

- `ST_IDLE`: the channel is not active.
- `ST_WARM`: the warm-up window is running.
- `ST_RUN`: accesses are not throttled.
- `ST_HOLD`: a stall is being counted out.

Its transitions are:

- Any state goes to `ST_IDLE` when channel-active is low.
- Any active state goes to `ST_WARM` on channel-start.
- `ST_IDLE` goes to `ST_WARM` when channel-active is high.
- `ST_WARM` goes to `ST_RUN` when warm-up is complete and no stall is taken.
- `ST_WARM` goes to `ST_HOLD` when warm-up is complete and a stall is taken.
- `ST_RUN` goes to `ST_HOLD` when a stall is taken.
- `ST_HOLD` goes to `ST_RUN` when the stall count expires.

Top module: `bw_throttle`

## Requirements
- R1: With code 2'b00 the stall output never rises.
- R2: With code 2'b01 no stall is inserted. The priority output is high once two accesses have completed since the channel became active or restarted. It goes high in the cycle after the clock edge that samples the second completion strobe.
- R3: With code 2'b10, a completion strobe that is eligible for a stall makes the stall output high for exactly 4 cycles. Those cycles start in the cycle after the edge that samples the strobe.
- R4: With code 2'b11, an eligible completion strobe makes the stall output high for exactly 8 cycles, with the same start as R3.
- R5: The first two completion strobes after activation or restart never cause a stall, whatever the code.
- R6: A completion strobe with the last-write flag high never causes a stall.
- R7: The priority output is low during the warm-up window and whenever the code is not 2'b01.
- R8: When channel-active is low at a clock edge, both outputs are low in the following cycle. The warm-up count is cleared, so the next activation again passes two accesses without throttling.
- R9: A channel-start pulse clears the warm-up count. The two strobes that follow it cause no stall.
- R10: The stall length is fixed by the code sampled with the strobe. A change of code during a stall does not shorten or lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bw_code | input | 2 | Bandwidth code: 00 free, 01 elevate, 10 short stall, 11 long stall |
| chan_active | input | 1 | High while a channel executes |
| chan_start | input | 1 | One-cycle pulse that restarts the warm-up count |
| access_done | input | 1 | One-cycle strobe per completed read/write access |
| last_write | input | 1 | Qualifies access_done as the final write of a minor loop |
| stall | output | 1 | Holds off the next access |
| prio_raise | output | 1 | Requests elevated priority at the bus arbiter |

## Verification
The same run of three access strobes is applied under each of the four codes. This separates the 0, 4 and 8 cycle stall lengths from the code that raises priority instead. The first two strobes of each run show that the warm-up window suppresses stalls and priority. A last-write strobe under the long code separates stall suppression at the end of a minor loop from the normal long stall. Dropping channel-active in the middle of a stall, pulsing channel-start, and changing the code during a stall show that the block clears its state, restarts warm-up, and latches the stall length when it loads.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    typedef enum logic [1:0] {
        BW_NONE    = 2'b00,
        BW_ELEVATE = 2'b01,
        BW_SHORT   = 2'b10,
        BW_LONG    = 2'b11
    } bw_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WARM,
        ST_RUN,
        ST_HOLD
    } thr_state_e;

endpackage

// File: rtl/bwt_warmup.sv
module bwt_warmup #(
    parameter int WARM_ACCESSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic done
);
    localparam int CW = $clog2(WARM_ACCESSES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WARM_ACCESSES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);

endmodule

// File: rtl/bwt_hold_timer.sv
module bwt_hold_timer #(
    parameter int SHORT_STALL = 4,
    parameter int LONG_STALL  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load,
    input  logic long_sel,
    output logic expiring
);
    localparam int MAXLEN = (LONG_STALL > SHORT_STALL) ? LONG_STALL : SHORT_STALL;
    localparam int CW = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_STALL);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_STALL);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= long_sel ? LONG_V : SHORT_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expiring = (cnt_q == CW'(1));

endmodule

// File: rtl/bwt_fsm.sv
module bwt_fsm
    import bwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bw_code,
    input  logic       chan_active,
    input  logic       chan_start,
    input  logic       access_done,
    input  logic       last_write,
    input  logic       warm_done,
    input  logic       hold_expiring,
    output logic       warm_clear,
    output logic       warm_count,
    output logic       timer_clear,
    output logic       timer_load,
    output logic       stall,
    output logic       prio_raise
);
    thr_state_e state_q, state_d;
    logic       stall_go;
    bw_code_e   code;

    assign code = bw_code_e'(bw_code);

    // an access qualifies for throttling only after warm-up, never at a minor loop end
    assign stall_go = access_done && !last_write && warm_done
                      && (code == BW_SHORT || code == BW_LONG);

    always_comb begin
        state_d = state_q;
        if (!chan_active) begin
            state_d = ST_IDLE;
        end else if (chan_start) begin
            state_d = ST_WARM;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_WARM;
                ST_WARM: if (warm_done) state_d = stall_go ? ST_HOLD : ST_RUN;
                ST_RUN:  if (stall_go)  state_d = ST_HOLD;
                ST_HOLD: if (hold_expiring) state_d = ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        warm_clear  = !chan_active || chan_start;
        timer_clear = !chan_active || chan_start;
        warm_count  = access_done && chan_active && !chan_start;
        timer_load  = 1'b0;
        stall       = 1'b0;
        prio_raise  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WARM: begin
                timer_load = (state_d == ST_HOLD);
                prio_raise = warm_done && (code == BW_ELEVATE);
            end
            ST_RUN: begin
                timer_load = (state_d == ST_HOLD);
                prio_raise = (code == BW_ELEVATE);
            end
            ST_HOLD: begin
                stall      = 1'b1;
                prio_raise = (code == BW_ELEVATE);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bw_throttle.sv
module bw_throttle #(
    parameter int WARM_ACCESSES = 2,
    parameter int SHORT_STALL   = 4,
    parameter int LONG_STALL    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bw_code,
    input  logic       chan_active,
    input  logic       chan_start,
    input  logic       access_done,
    input  logic       last_write,
    output logic       stall,
    output logic       prio_raise
);
    logic warm_clear, warm_count, warm_done;
    logic timer_clear, timer_load, hold_expiring;

    bwt_warmup #(.WARM_ACCESSES(WARM_ACCESSES)) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (warm_clear),
        .count_en (warm_count),
        .done     (warm_done)
    );

    bwt_hold_timer #(.SHORT_STALL(SHORT_STALL), .LONG_STALL(LONG_STALL)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (timer_clear),
        .load     (timer_load),
        .long_sel (bw_code[0]),
        .expiring (hold_expiring)
    );

    bwt_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bw_code       (bw_code),
        .chan_active   (chan_active),
        .chan_start    (chan_start),
        .access_done   (access_done),
        .last_write    (last_write),
        .warm_done     (warm_done),
        .hold_expiring (hold_expiring),
        .warm_clear    (warm_clear),
        .warm_count    (warm_count),
        .timer_clear   (timer_clear),
        .timer_load    (timer_load),
        .stall         (stall),
        .prio_raise    (prio_raise)
    );

endmodule

// File: rtl/bw_throttle_chk.sv
module bw_throttle_chk #(
    parameter int SHORT_STALL = 4,
    parameter int LONG_STALL  = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bw_code,
    input logic       chan_active,
    input logic       chan_start,
    input logic       access_done,
    input logic       last_write,
    input logic       warm_done,
    input logic       stall,
    input logic       prio_raise
);
    logic [7:0] len_q;
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= 8'd0;
            run_q <= 8'd0;
        end else begin
            if (!stall) len_q <= bw_code[0] ? 8'(LONG_STALL) : 8'(SHORT_STALL);
            run_q <= stall ? run_q + 8'd1 : 8'd0;
        end
    end

    a_r1_free_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_code == 2'b00 && !stall) |=> !stall);

    a_r2_elevate_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_code == 2'b01 && !stall) |=> !stall);

    a_r3_hold_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && run_q == len_q - 8'd1) |=> !stall);

    a_r4_hold_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && run_q < len_q - 8'd1 && chan_active && !chan_start) |=> stall);

    a_r5_r6_stall_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> ($past(access_done) && $past(warm_done) && !$past(last_write)));

    a_r7_prio_needs_warm: assert property (@(posedge clk) disable iff (!rst_n)
        prio_raise |-> warm_done);

    a_r8_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_active |=> (!stall && !prio_raise));

    a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_start && chan_active) |=> !stall);

endmodule

bind bw_throttle bw_throttle_chk #(.SHORT_STALL(SHORT_STALL), .LONG_STALL(LONG_STALL)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bw_code     (bw_code),
    .chan_active (chan_active),
    .chan_start  (chan_start),
    .access_done (access_done),
    .last_write  (last_write),
    .warm_done   (warm_done),
    .stall       (stall),
    .prio_raise  (prio_raise)
);

// File: tb/bw_throttle_tb_top.sv
module bw_throttle_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bw_code = 2'b00;
    logic       chan_active = 1'b0;
    logic       chan_start = 1'b0;
    logic       access_done = 1'b0;
    logic       last_write = 1'b0;
    logic       stall;
    logic       prio_raise;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bw_throttle dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bw_code     (bw_code),
        .chan_active (chan_active),
        .chan_start  (chan_start),
        .access_done (access_done),
        .last_write  (last_write),
        .stall       (stall),
        .prio_raise  (prio_raise)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one access strobe; returns the number of stall cycles that follow it
    task automatic access(input bit last, input bit chg, input logic [1:0] newc, output int n);
        @(negedge clk);
        access_done = 1'b1;
        last_write  = last;
        @(negedge clk);
        access_done = 1'b0;
        last_write  = 1'b0;
        n = 0;
        while (stall && n < 20) begin
            if (chg && n == 0) bw_code = newc;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic activate(input logic [1:0] code);
        @(negedge clk);
        chan_active = 1'b0;
        bw_code = code;
        @(negedge clk);
        chan_active = 1'b1;
        @(negedge clk);
    endtask

    task automatic warm_pair(input string req);
        int n;
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 0, req, n, 0);
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 0, req, n, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(stall == 1'b0, "R8 reset stall", stall, 0);
        check(prio_raise == 1'b0, "R8 reset prio", prio_raise, 0);
    endtask

    task automatic t_free();
        int n;
        activate(2'b00);
        warm_pair("R5 warm code00");
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 0, "R1 code00 no stall", n, 0);
        check(prio_raise == 1'b0, "R7 code00 prio low", prio_raise, 0);
    endtask

    task automatic t_short();
        int n;
        activate(2'b10);
        warm_pair("R5 warm code10");
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 4, "R3 code10 stall length", n, 4);
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 4, "R3 code10 repeat", n, 4);
    endtask

    task automatic t_long();
        int n;
        activate(2'b11);
        warm_pair("R5 warm code11");
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 8, "R4 code11 stall length", n, 8);
        access(1'b1, 1'b0, 2'b00, n);
        check(n == 0, "R6 last write no stall", n, 0);
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 8, "R4 after minor loop end", n, 8);
    endtask

    task automatic t_elevate();
        int n;
        activate(2'b01);
        check(prio_raise == 1'b0, "R7 prio low at start", prio_raise, 0);
        access(1'b0, 1'b0, 2'b00, n);
        check(prio_raise == 1'b0, "R7 prio low after one", prio_raise, 0);
        access(1'b0, 1'b0, 2'b00, n);
        check(prio_raise == 1'b1, "R2 prio high after two", prio_raise, 1);
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 0, "R2 code01 no stall", n, 0);
        check(prio_raise == 1'b1, "R2 prio stays high", prio_raise, 1);
        bw_code = 2'b10;
        @(negedge clk);
        check(prio_raise == 1'b0, "R7 prio low on other code", prio_raise, 0);
    endtask

    task automatic t_drop();
        int n;
        activate(2'b11);
        warm_pair("R5 warm drop");
        @(negedge clk);
        access_done = 1'b1;
        @(negedge clk);
        access_done = 1'b0;
        @(negedge clk);
        check(stall == 1'b1, "R4 stall before drop", stall, 1);
        chan_active = 1'b0;
        @(negedge clk);
        check(stall == 1'b0, "R8 stall cleared on drop", stall, 0);
        chan_active = 1'b1;
        bw_code = 2'b10;
        @(negedge clk);
        warm_pair("R8 warm again after drop");
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 4, "R8 throttles after new warm-up", n, 4);
    endtask

    task automatic t_restart();
        int n;
        activate(2'b10);
        warm_pair("R5 warm restart");
        @(negedge clk);
        chan_start = 1'b1;
        @(negedge clk);
        chan_start = 1'b0;
        warm_pair("R9 warm after restart");
        access(1'b0, 1'b0, 2'b00, n);
        check(n == 4, "R9 throttles after restart", n, 4);
    endtask

    task automatic t_latch();
        int n;
        activate(2'b11);
        warm_pair("R5 warm latch");
        access(1'b0, 1'b1, 2'b10, n);
        check(n == 8, "R10 code change keeps long", n, 8);
        access(1'b0, 1'b1, 2'b11, n);
        check(n == 4, "R10 code change keeps short", n, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_free();
        t_short();
        t_long();
        t_elevate();
        t_drop();
        t_restart();
        t_latch();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule